// File: doc/BRIEF.md
# Four-Function ALU with Condition Flags

This block is a purely combinational integer arithmetic logic unit. It accepts two 32-bit operands and a 2-bit opcode. It returns one 32-bit result and three single-bit condition indications. A flag reads 1 when its condition holds and 0 when it does not.

Four operation units see both operands at the same moment: an adder, a bitwise OR, a bitwise AND and an equality comparator. None of them is ever switched off. The opcode acts only as the select of an output multiplexer. The flag logic then inspects the selected value. The adder's internal structure can be chosen by a parameter: a behavioural sum, a bit-serial ripple chain, or blocked carry-select. The ports and results are the same for all three.

Top module: `alu4_core`

## Requirements
- R1: With opcode 2'b00 the result is (op_a + op_b) modulo 2^32. For example, 6 plus 8 gives 14, with flag_neg, flag_zero and flag_carry all 0.
- R2: With opcode 2'b01 the result is the bitwise OR of op_a and op_b.
- R3: With opcode 2'b10 the result is the bitwise AND of op_a and op_b.
- R4: With opcode 2'b11 the result is 32'h0000_0001 when op_a equals op_b, and 32'h0000_0000 otherwise.
- R5: flag_zero is 1 exactly when the 32-bit result is all zeros, for every opcode.
- R6: flag_neg equals bit 31 of the result, for every opcode.
- R7: For opcode 2'b00, flag_carry is the carry out of bit 31 of the unsigned 33-bit sum. For the other three opcodes it is 0.
- R8: The outputs depend only on the present inputs: no clock and no stored state. Any new input combination is reflected once the logic settles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| opcode | input | 2 | Operation select: 00 add, 01 or, 10 and, 11 equals |
| result | output | 32 | Selected operation output |
| flag_neg | output | 1 | Bit 31 of the result |
| flag_zero | output | 1 | Result is all zeros |
| flag_carry | output | 1 | Carry out of the add; 0 for other operations |

## Verification
Every operand pair with values 0 to 15 is applied under all four opcodes. This tests the low-bit arithmetic and logic of each operation, and the equals output on both matching and non-matching pairs.

A second set of corner operands drives each flag at its boundary:
- all-ones plus one gives a zero result together with a carry;
- the top bit alone drives the negative flag;
- equal wide values drive the equals output.

Random wide operand pairs then check the carry propagation across the adder's block boundaries. Stepping the opcode over a fixed operand pair checks that the selection alone changes the outputs, with no state carried over.

// File: rtl/alu4_pkg.sv
package alu4_pkg;

   typedef enum logic [1:0] {
      OPC_ADD = 2'b00,
      OPC_OR  = 2'b01,
      OPC_AND = 2'b10,
      OPC_EQ  = 2'b11
   } alu_opc_e;

   typedef enum logic [1:0] {
      SUM_BEHAV  = 2'b00,
      SUM_RIPPLE = 2'b01,
      SUM_CSEL   = 2'b10
   } sum_impl_e;

   localparam int unsigned OPC_W = 2;

endpackage

// File: rtl/alu4_adder.sv
module alu4_adder #(
   parameter int unsigned          WIDTH = 32,
   parameter alu4_pkg::sum_impl_e  IMPL  = alu4_pkg::SUM_CSEL,
   parameter int unsigned          BLK   = 8
) (
   input  logic [WIDTH-1:0] in_x,
   input  logic [WIDTH-1:0] in_y,
   output logic [WIDTH-1:0] sum,
   output logic             cout
);

   localparam int unsigned NBLK = (BLK == 0) ? 1 : WIDTH / BLK;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("alu4_adder: WIDTH must be at least 2");
      end

      if (IMPL == alu4_pkg::SUM_BEHAV) begin : g_behav
         logic [WIDTH:0] full;
         assign full = {1'b0, in_x} + {1'b0, in_y};
         assign sum  = full[WIDTH-1:0];
         assign cout = full[WIDTH];
      end
      else if (IMPL == alu4_pkg::SUM_RIPPLE) begin : g_ripple
         logic [WIDTH:0] cy;
         assign cy[0] = 1'b0;
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            logic prop;
            assign prop      = in_x[i] ^ in_y[i];
            assign sum[i]    = prop ^ cy[i];
            assign cy[i+1]   = (in_x[i] & in_y[i]) | (cy[i] & prop);
         end
         assign cout = cy[WIDTH];
      end
      else begin : g_csel
         if (BLK == 0 || (WIDTH % BLK) != 0) begin : g_bad_blk
            $error("alu4_adder: BLK must divide WIDTH for carry-select");
         end
         logic [NBLK:0] bcy;
         assign bcy[0] = 1'b0;
         for (genvar j = 0; j < NBLK; j++) begin : g_blk
            logic [BLK:0] s_lo;
            logic [BLK:0] s_hi;
            assign s_lo = {1'b0, in_x[j*BLK +: BLK]} + {1'b0, in_y[j*BLK +: BLK]};
            assign s_hi = {1'b0, in_x[j*BLK +: BLK]} + {1'b0, in_y[j*BLK +: BLK]}
                        + {{BLK{1'b0}}, 1'b1};
            assign sum[j*BLK +: BLK] = bcy[j] ? s_hi[BLK-1:0] : s_lo[BLK-1:0];
            assign bcy[j+1]          = bcy[j] ? s_hi[BLK]     : s_lo[BLK];
         end
         assign cout = bcy[NBLK];
      end
   endgenerate

endmodule

// File: rtl/alu4_logic.sv
module alu4_logic #(
   parameter int unsigned WIDTH = 32
) (
   input  logic [WIDTH-1:0] in_x,
   input  logic [WIDTH-1:0] in_y,
   output logic [WIDTH-1:0] or_out,
   output logic [WIDTH-1:0] and_out,
   output logic [WIDTH-1:0] eq_out
);

   logic [WIDTH-1:0] diff_bits;
   logic             same;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("alu4_logic: WIDTH must be at least 2");
      end
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         assign or_out[i]    = in_x[i] | in_y[i];
         assign and_out[i]   = in_x[i] & in_y[i];
         assign diff_bits[i] = in_x[i] ^ in_y[i];
      end
   endgenerate

   assign same   = ~|diff_bits;
   assign eq_out = {{(WIDTH-1){1'b0}}, same};

   always_comb begin
      a_r4_eq_upper_clear: assert (eq_out[WIDTH-1:1] == '0)
         else $error("R4: equals output has upper bits set");
   end

endmodule

// File: rtl/alu4_flags.sv
module alu4_flags #(
   parameter int unsigned WIDTH = 32
) (
   input  logic [WIDTH-1:0] sel_val,
   input  logic             is_add,
   input  logic             add_cout,
   output logic             f_neg,
   output logic             f_zero,
   output logic             f_carry
);

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("alu4_flags: WIDTH must be at least 2");
      end
   endgenerate

   assign f_neg   = sel_val[WIDTH-1];
   assign f_zero  = (sel_val == '0);
   assign f_carry = is_add & add_cout;

endmodule

// File: rtl/alu4_core.sv
module alu4_core #(
   parameter int unsigned         WIDTH    = 32,
   parameter alu4_pkg::sum_impl_e SUM_IMPL = alu4_pkg::SUM_CSEL,
   parameter int unsigned         SUM_BLK  = 8
) (
   input  logic [WIDTH-1:0]             op_a,
   input  logic [WIDTH-1:0]             op_b,
   input  logic [alu4_pkg::OPC_W-1:0]   opcode,
   output logic [WIDTH-1:0]             result,
   output logic                         flag_neg,
   output logic                         flag_zero,
   output logic                         flag_carry
);

   import alu4_pkg::*;

   logic [WIDTH-1:0] sum_v;
   logic             sum_c;
   logic [WIDTH-1:0] or_v;
   logic [WIDTH-1:0] and_v;
   logic [WIDTH-1:0] eq_v;
   logic [WIDTH-1:0] pick;
   alu_opc_e         opc;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("alu4_core: WIDTH must be at least 2");
      end
   endgenerate

   assign opc = alu_opc_e'(opcode);

   alu4_adder #(.WIDTH(WIDTH), .IMPL(SUM_IMPL), .BLK(SUM_BLK)) u_add (
      .in_x (op_a),
      .in_y (op_b),
      .sum  (sum_v),
      .cout (sum_c)
   );

   alu4_logic #(.WIDTH(WIDTH)) u_logic (
      .in_x    (op_a),
      .in_y    (op_b),
      .or_out  (or_v),
      .and_out (and_v),
      .eq_out  (eq_v)
   );

   always_comb begin
      unique case (opc)
         OPC_ADD: pick = sum_v;
         OPC_OR:  pick = or_v;
         OPC_AND: pick = and_v;
         OPC_EQ:  pick = eq_v;
         default: pick = '0;
      endcase
   end

   alu4_flags #(.WIDTH(WIDTH)) u_flags (
      .sel_val  (pick),
      .is_add   (opc == OPC_ADD),
      .add_cout (sum_c),
      .f_neg    (flag_neg),
      .f_zero   (flag_zero),
      .f_carry  (flag_carry)
   );

   assign result = pick;

   always_comb begin
      if (opc == OPC_ADD) begin
         a_r1_sum_matches: assert ({flag_carry, result} == ({1'b0, op_a} + {1'b0, op_b}))
            else $error("R1/R7: adder output disagrees with arithmetic sum");
      end
      if (opc == OPC_EQ) begin
         a_r4_eq_bit: assert (result[0] == (op_a == op_b))
            else $error("R4: equals bit wrong");
      end
      if (opc != OPC_ADD) begin
         a_r7_carry_quiet: assert (!flag_carry)
            else $error("R7: carry set outside add");
      end
      a_r6_neg_top: assert (flag_neg == result[WIDTH-1])
         else $error("R6: negative flag differs from top bit");
      a_r5_zero_any: assert (flag_zero == (result == '0))
         else $error("R5: zero flag differs from result");
   end

endmodule

// File: tb/tb_alu4_core.sv
module tb_alu4_core;

   logic        clk = 1'b0;
   logic [31:0] op_a;
   logic [31:0] op_b;
   logic [1:0]  opcode;
   logic [31:0] result;
   logic        flag_neg;
   logic        flag_zero;
   logic        flag_carry;

   int unsigned n_checks = 0;
   int unsigned n_errors = 0;
   bit          finished = 1'b0;

   always #5 clk = ~clk;

   alu4_core dut (
      .op_a       (op_a),
      .op_b       (op_b),
      .opcode     (opcode),
      .result     (result),
      .flag_neg   (flag_neg),
      .flag_zero  (flag_zero),
      .flag_carry (flag_carry)
   );

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_errors++;
         $display("FAIL %s: a=%h b=%h op=%b got=%h exp=%h", req, op_a, op_b, opcode, got, exp);
      end
   endtask

   task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic [1:0] op);
      logic [32:0] s;
      logic [31:0] r;
      logic        c;
      @(posedge clk);
      op_a = a; op_b = b; opcode = op;
      s = {1'b0, a} + {1'b0, b};
      c = 1'b0;
      case (op)
         2'b00: begin r = s[31:0]; c = s[32]; end
         2'b01: r = a | b;
         2'b10: r = a & b;
         default: r = (a == b) ? 32'd1 : 32'd0;
      endcase
      @(negedge clk);
      case (op)
         2'b00: chk("R1", result, r);
         2'b01: chk("R2", result, r);
         2'b10: chk("R3", result, r);
         default: chk("R4", result, r);
      endcase
      chk("R5", {31'd0, flag_zero},  {31'd0, (r == 32'd0)});
      chk("R6", {31'd0, flag_neg},   {31'd0, r[31]});
      chk("R7", {31'd0, flag_carry}, {31'd0, c});
   endtask

   localparam int NCORN = 10;
   logic [31:0] corner [NCORN] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h8000_0000,
                                   32'h7FFF_FFFF, 32'h0000_00FF, 32'h0000_0100,
                                   32'hAAAA_5555, 32'h5555_AAAA, 32'hFFFF_FFFE};

   initial begin
      op_a = '0; op_b = '0; opcode = 2'b00;
      // idle inputs: zero sum, zero flag only
      @(negedge clk);
      chk("R5 idle result", result, 32'd0);
      chk("R5 idle zero", {31'd0, flag_zero}, 32'd1);

      // R1 worked example: 6 + 8
      apply(32'd6, 32'd8, 2'b00);
      chk("R1 six plus eight", {29'd0, flag_neg, flag_zero, flag_carry}, 32'd0);

      // R7 all-ones plus one: zero result with carry
      apply(32'hFFFF_FFFF, 32'd1, 2'b00);
      chk("R7 wrap carry", {31'd0, flag_carry}, 32'd1);
      chk("R5 wrap zero", {31'd0, flag_zero}, 32'd1);

      // R4 equal wide operands
      apply(32'hDEAD_BEEF, 32'hDEAD_BEEF, 2'b11);
      chk("R4 equal wide", result, 32'd1);

      // exhaustive small operands, every opcode
      for (int op = 0; op < 4; op++)
         for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++)
               apply(32'(a), 32'(b), 2'(op));

      // corner pairs, every opcode
      for (int op = 0; op < 4; op++)
         for (int i = 0; i < NCORN; i++)
            for (int j = 0; j < NCORN; j++)
               apply(corner[i], corner[j], 2'(op));

      // R8: same operands, opcode stepping only
      for (int k = 0; k < 8; k++)
         apply(32'h8000_00F0, 32'h8000_000F, 2'(k % 4));

      // random wide pairs, also random equal pairs
      for (int n = 0; n < 600; n++) begin
         logic [31:0] ra;
         logic [31:0] rb;
         ra = $urandom;
         rb = (n % 7 == 0) ? ra : $urandom;
         apply(ra, rb, 2'(n % 4));
      end

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: got=timeout exp=completion");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

endmodule